// File: doc/BRIEF.md
# Configurable 8/16-Bit Up Timer with Power-of-Two Prescaler

The block is an up-counting timer/counter whose width can be switched at run time between an 8-bit and a 16-bit count. Each increment comes from one of two sources. The first is a one-cycle instruction-tick enable from the core clock domain. The second is an external pin, which is synchronized first; either its rising or its falling edge can be chosen as the active edge.

Between the chosen source and the counter sits a prescaler. It divides the event rate by 2 to the power (code + 1), with a 3-bit code. A control bit can also take the prescaler out of the path, so that every event counts. Software can preload the count through a write port. Every wrap of the active width sets a sticky overflow flag, which stays set until a clear strobe removes it. An interrupt controller reads that flag.

Top module: `tmr_unit`

## Requirements
- R1: After reset `count_o` is 0 and `ovf_flag_o` is 0. While `run_en_i` is 0, the count and the prescaler hold their values.
- R2: With `narrow_i`=1 only bits [7:0] count. They wrap from 0xFF to 0x00, and bits [15:8] keep their value.
- R3: With `narrow_i`=0 all 16 bits count, wrapping from 0xFFFF to 0x0000.
- R4: With `ext_sel_i`=0 a high `tick_i` is the count event and the pin is ignored. With `ext_sel_i`=1 a pin edge is the count event and `tick_i` is ignored.
- R5: With the pin source, `fall_sel_i`=0 counts low-to-high transitions and `fall_sel_i`=1 counts high-to-low transitions.
- R6: With `ps_bypass_i`=1 every event increments the count.
- R7: With `ps_bypass_i`=0 the count increments once per 2^(`ps_code_i`+1) events: code 0 gives 2, and code 7 gives 256.
- R8: A wrap of the active width sets `ovf_flag_o`. The flag stays set until `flag_clr_i` is high on a cycle with no new wrap; when a wrap and the clear occur in the same cycle, the wrap wins.
- R9: `wr_en_i` loads `wr_data_i` into all 16 count bits on the next edge. The load takes priority over an increment in the same cycle, and it also zeroes the prescaler's internal count.
- R10: The pin passes through two synchronizing flops. A transition set up before clock edge k changes `count_o` at edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_en_i | input | 1 | 1 = timer runs, 0 = timer holds |
| narrow_i | input | 1 | 1 = 8-bit count, 0 = 16-bit count |
| ext_sel_i | input | 1 | 1 = external pin source, 0 = instruction tick |
| fall_sel_i | input | 1 | 1 = falling pin edge, 0 = rising pin edge |
| ps_bypass_i | input | 1 | 1 = prescaler bypassed, 0 = prescaler used |
| ps_code_i | input | 3 | Prescale code, division by 2^(code+1) |
| tick_i | input | 1 | Instruction-cycle enable |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| wr_en_i | input | 1 | Count load strobe |
| wr_data_i | input | 16 | Count load value |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: a 16-bit count, an 8-bit narrow field and a 3-bit prescale code, so the full 256-event prescale and both wrap points are in reach. Directed preloads next to 0xFF and 0xFFFF reach both wraps in a few cycles. Random control settings and random loads exercise the prescaler reset, the write-over-increment priority and the flag set-versus-clear priority against a cycle model. The pin tests measure the two-flop latency and both edge polarities.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned NAR_W   = 8;
  localparam int unsigned CODE_W  = 3;

  typedef struct packed {
    logic             run;
    logic             narrow;
    logic             ext;
    logic             fall;
    logic             bypass;
    logic [CODE_W-1:0] code;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  assign pulse_o = fall_i ? (prev_q & ~cur) : (~prev_q & cur);

  // a detected edge cannot repeat on the next cycle
  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o && $stable(fall_i) |=> !pulse_o); // R5
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned CODE_W = 3,
  localparam int unsigned PS_W  = 2 ** CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic              bypass_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  output logic              inc_o
);
  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] lim;
  logic            last;

  assign lim  = {PS_W{1'b1}} >> (PS_W - 1 - int'(code_i));
  assign last = (ps_q >= lim);  // tolerate a code lowered mid-count

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ps_q <= '0;
    else if (clr_i)             ps_q <= '0;
    else if (ev_i && !bypass_i) ps_q <= last ? '0 : ps_q + 1'b1;
  end

  assign inc_o = bypass_i ? ev_i : (ev_i & last);

  AST_PS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ps_q == '0); // R9
  AST_PS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i && !clr_i |=> $stable(ps_q)); // R1
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NAR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             narrow_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [NAR_W-1:0] lo;
  logic             wrap;
  logic             ovf;

  assign lo   = cnt_q[NAR_W-1:0];
  assign wrap = narrow_i ? (&lo) : (&cnt_q);
  assign ovf  = inc_i & ~wr_en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_en_i)  cnt_q <= wr_data_i;
    else if (inc_i) begin
      if (narrow_i) cnt_q <= {cnt_q[CNT_W-1:NAR_W], lo + 1'b1};
      else          cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_o <= 1'b0;
    else if (ovf)        flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

  assign cnt_o = cnt_q;

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q == $past(wr_data_i)); // R9
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_en_i && wrap |=> flag_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o); // R8
  AST_WIDE_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_en_i && !narrow_i && (&cnt_q) |=> cnt_q == '0); // R3
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_en_i,
  input  logic              narrow_i,
  input  logic              ext_sel_i,
  input  logic              fall_sel_i,
  input  logic              ps_bypass_i,
  input  logic [CODE_W-1:0] ps_code_i,
  input  logic              tick_i,
  input  logic              ext_pin_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_flag_o
);
  tmr_cfg_t cfg;
  logic     pin_ev;
  logic     ev;
  logic     inc;

  assign cfg = '{run: run_en_i, narrow: narrow_i, ext: ext_sel_i,
                 fall: fall_sel_i, bypass: ps_bypass_i, code: ps_code_i};

  tmr_edge #(.SYNC_STAGES(2)) u_edge (
    .clk_i, .rst_ni, .pin_i(ext_pin_i), .fall_i(cfg.fall), .pulse_o(pin_ev)
  );

  assign ev = cfg.run & (cfg.ext ? pin_ev : tick_i);

  tmr_prescale #(.CODE_W(CODE_W)) u_ps (
    .clk_i, .rst_ni, .ev_i(ev), .bypass_i(cfg.bypass), .code_i(cfg.code),
    .clr_i(wr_en_i), .inc_o(inc)
  );

  tmr_count #(.CNT_W(CNT_W), .NAR_W(NAR_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(inc), .narrow_i(cfg.narrow), .wr_en_i,
    .wr_data_i, .flag_clr_i, .cnt_o(count_o), .flag_o(ovf_flag_o)
  );

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i && !wr_en_i |=> $stable(count_o)); // R1
  AST_NARROW_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_i && !wr_en_i |=> $stable(count_o[CNT_W-1:NAR_W])); // R2
  AST_TICK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_i && !pin_ev && !wr_en_i |=> $stable(count_o)); // R4
endmodule

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, narrow = 0, ext_sel = 0, fall_sel = 0, bypass = 1;
  logic [2:0] code = 0;
  logic tick = 0, pin = 0, wr_en = 0, clr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] count;
  logic flag;

  int checks = 0, errors = 0;
  logic [15:0] m_cnt = 0;
  int m_ps = 0;
  logic m_flag = 0;

  always #5 clk = ~clk;

  tmr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en), .narrow_i(narrow),
    .ext_sel_i(ext_sel), .fall_sel_i(fall_sel), .ps_bypass_i(bypass),
    .ps_code_i(code), .tick_i(tick), .ext_pin_i(pin), .wr_en_i(wr_en),
    .wr_data_i(wdata), .flag_clr_i(clr), .count_o(count), .ovf_flag_o(flag)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle of the internal-source path; starts and ends at a negedge
  task automatic step(string tag, logic r, logic n, logic b, logic [2:0] c,
                      logic t, logic w, logic [15:0] d, logic cl);
    logic ev, inc, wrap;
    int lim;
    run_en = r; narrow = n; bypass = b; code = c; tick = t;
    wr_en = w; wdata = d; clr = cl; ext_sel = 0;
    @(posedge clk);
    ev = r & t; inc = 0; lim = (2 << c) - 1;
    if (b) inc = ev;
    else if (ev) begin
      if (m_ps >= lim) begin m_ps = 0; inc = 1; end
      else m_ps++;
    end
    wrap = n ? (m_cnt[7:0] == 8'hFF) : (m_cnt == 16'hFFFF);
    if (w) begin m_cnt = d; m_ps = 0; end
    else if (inc) begin
      if (n) m_cnt[7:0] = m_cnt[7:0] + 8'd1; else m_cnt = m_cnt + 16'd1;
    end
    if (inc && !w && wrap) m_flag = 1;
    else if (cl) m_flag = 0;
    @(negedge clk);
    wr_en = 0; clr = 0; tick = 0;
    chk({tag, " count"}, count, m_cnt);
    chk({tag, " flag"}, {15'd0, flag}, {15'd0, m_flag});
  endtask

  task automatic cycles(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] base;
    void'($urandom(32'd1234));
    cycles(3);
    chk("R1 reset count", count, 16'h0);
    chk("R1 reset flag", {15'd0, flag}, 16'h0);
    rst_n = 1;
    cycles(1);

    // R6 bypass: every tick counts
    for (int i = 0; i < 5; i++) step("R6", 1, 0, 1, 0, 1, 0, 0, 0);
    chk("R6 five ticks", count, 16'd5);
    // R1 run off holds
    for (int i = 0; i < 4; i++) step("R1", 0, 0, 1, 0, 1, 0, 0, 0);
    chk("R1 held", count, 16'd5);
    // R3 16-bit wrap
    step("R9", 1, 0, 1, 0, 0, 1, 16'hFFFE, 0);
    step("R3", 1, 0, 1, 0, 1, 0, 0, 0);
    step("R3", 1, 0, 1, 0, 1, 0, 0, 0);
    chk("R3 wrapped", count, 16'h0000);
    chk("R8 flag set", {15'd0, flag}, 16'h1);
    step("R8", 1, 0, 1, 0, 0, 0, 0, 1);
    chk("R8 cleared", {15'd0, flag}, 16'h0);
    // R2 narrow wrap keeps upper byte
    step("R9", 1, 1, 1, 0, 0, 1, 16'h12FF, 0);
    step("R2", 1, 1, 1, 0, 1, 0, 0, 1); // wrap and clear together: wrap wins
    chk("R2 narrow wrap", count, 16'h1200);
    chk("R8 set beats clear", {15'd0, flag}, 16'h1);
    // R9 write beats increment
    step("R9", 1, 0, 1, 0, 1, 1, 16'h4321, 0);
    chk("R9 write wins", count, 16'h4321);
    // R7 divide by 8
    step("R9", 1, 0, 0, 3'd2, 0, 1, 16'h0, 0);
    for (int i = 0; i < 16; i++) step("R7", 1, 0, 0, 3'd2, 1, 0, 0, 0);
    chk("R7 div8", count, 16'd2);
    // R9 write clears prescaler mid-count
    for (int i = 0; i < 5; i++) step("R7", 1, 0, 0, 3'd2, 1, 0, 0, 0);
    step("R9", 1, 0, 0, 3'd2, 1, 1, 16'h0, 0);
    for (int i = 0; i < 7; i++) step("R9", 1, 0, 0, 3'd2, 1, 0, 0, 0);
    chk("R9 ps cleared", count, 16'd0);
    // R7 divide by 256
    for (int i = 0; i < 512; i++) step("R7", 1, 0, 0, 3'd7, 1, 0, 0, 0);
    chk("R7 div256", count, 16'd2);

    // random mix
    for (int i = 0; i < 600; i++)
      step("R7 rnd", ($urandom % 8) != 0, $urandom % 2, $urandom % 2,
           3'($urandom % 3), $urandom % 2, ($urandom % 40) == 0,
           16'($urandom), ($urandom % 16) == 0);

    // external source
    run_en = 1; bypass = 1; narrow = 0; fall_sel = 0; pin = 0;
    wr_en = 1; wdata = 16'h0; ext_sel = 1; tick = 1;
    cycles(1); wr_en = 0;
    cycles(4);
    chk("R4 tick ignored on pin source", count, 16'h0);
    pin = 1;
    cycles(2);
    chk("R10 not before two flops", count, 16'h0);
    cycles(1);
    chk("R10 counted at third edge", count, 16'h1);
    cycles(3);
    pin = 0; cycles(4);
    chk("R5 rising only", count, 16'h1);
    fall_sel = 1; cycles(2);
    pin = 1; cycles(4);
    chk("R5 no count on rise in fall mode", count, 16'h1);
    pin = 0; cycles(4);
    chk("R5 count on fall", count, 16'h2);
    ext_sel = 0; tick = 0; base = count;
    for (int i = 0; i < 3; i++) begin pin = 1; cycles(4); pin = 0; cycles(4); end
    chk("R4 pin ignored on tick source", count, base);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule